// File: doc/BRIEF.md
# Target Flash Erase Sequencer

This block runs the complete erase procedure for the flash of a debug target. A single command starts it. The command selects either a whole-array (mass) erase or an information-segment erase, and it supplies the erase address, the number of timing pulses and the pulse half-period. The sequencer then sends a fixed series of operations, one at a time with a valid/ready handshake, to a lower engine that does the actual scan shifting:

- a CPU halt;
- three flash-controller register writes;
- the dummy write that starts the erase;
- a control-word shift that returns the target to read mode.

The target clock line is driven low just before that control-word shift. After it, the sequencer produces the requested number of full low/high target-clock cycles. These pulses clock the target's flash timing generator, so the erase is timed entirely by the debugger.

Every value written to the flash control registers carries 0xA5 in its high byte. The value written to the lock register differs between the two erase kinds. `busy_o` stays high from the cycle after the command is accepted until the last pulse is complete. `done_o` marks the end of the erase with a single-cycle pulse.

Top module: `fes_erase_seq`

## Requirements
- R1: After reset `busy_o`, `op_valid` and `done_o` are 0 and `tclk_o` is 1.
- R2: `cmd_valid` high while idle is accepted. In the next cycle `busy_o` is 1 and `op_valid` shows a halt operation (`op_kind` 0 = halt, 1 = memory write, 2 = control-word shift).
- R3: Six operations are issued in this order: halt; write 0x0128 (erase code); write 0x012A with 0xA540; write 0x012C (lock value); write the erase address with 0x55AA; control shift of 0x2409. Each one holds `op_kind`/`op_addr`/`op_data` stable until `op_ready` is seen. Halt carries address and data 0, and the control shift carries address 0.
- R4: The erase code written to 0x0128 is 0xA506 when `cmd_info` is 0 (mass) and 0xA502 when `cmd_info` is 1 (segment).
- R5: The lock value written to 0x012C is 0xA500 for mass erase and 0xA540 for information-segment erase.
- R6: `tclk_o` goes low in the cycle after the dummy write is accepted, and it is low while the control-shift operation is offered.
- R7: After the control shift is accepted, `tclk_o` makes exactly `cmd_pulses` cycles. Each cycle is low for H clocks and then high for H clocks, where H = `cfg_half`, and a value of 0 counts as 1. The line is high when the erase finishes.
- R8: With `cmd_pulses` = 0 no pulse is made, and `done_o` rises in the cycle after the control shift is accepted, with `tclk_o` high.
- R9: `done_o` is a single-cycle pulse in the cycle after the last high phase. `busy_o` is still 1 in that cycle and is 0 in the next one.
- R10: `cmd_valid` while busy is ignored: the running erase keeps its own kind and parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start request |
| cmd_info | input | 1 | 1 = information-segment erase, 0 = mass erase |
| cmd_addr | input | ADDR_W | Erase (dummy write) address |
| cmd_pulses | input | CNT_W | Number of target-clock pulses |
| cfg_half | input | HALF_W | Pulse half-period in clocks (0 treated as 1) |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | Erase complete, one cycle |
| op_valid | output | 1 | Operation offered to the scan engine |
| op_kind | output | 2 | 0 halt, 1 memory write, 2 control shift |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | DATA_W | Operation data |
| op_ready | input | 1 | Scan engine accepts the operation |
| tclk_o | output | 1 | Target clock line |

## Verification
Each operation appears on `op_valid` in the cycle after the accept or handshake that precedes it. The bench samples it at the falling edge that follows that rising edge, and it stalls `op_ready` for a random 0 to 2 cycles to confirm that the operation holds steady. The target clock is sampled once per cycle from the cycle after the control shift is accepted. Every low and high run is measured against H, and rising transitions are counted until `done_o` appears, which is due 2·H·N cycles after that handshake. `busy_o` is checked high in the `done_o` cycle and low one cycle later. A second command is held on the inputs during an erase, and the later lock value and the clean finish show that it was ignored.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic [1:0] {
      OPK_HALT = 2'd0,
      OPK_MEMWR = 2'd1,
      OPK_CTL = 2'd2
   } op_kind_t;

   localparam int unsigned STEP_W = 3;
   localparam logic [STEP_W-1:0] STEP_DUMMY = 3'd4;
   localparam logic [STEP_W-1:0] STEP_LAST = 3'd5;

   localparam logic [15:0] REG_MODE = 16'h0128;
   localparam logic [15:0] REG_CLKSEL = 16'h012A;
   localparam logic [15:0] REG_LOCK = 16'h012C;

   localparam logic [15:0] CODE_MASS = 16'hA506;
   localparam logic [15:0] CODE_SEG = 16'hA502;
   localparam logic [15:0] CLKSEL_VAL = 16'hA540;
   localparam logic [15:0] LOCK_MAIN = 16'hA500;
   localparam logic [15:0] LOCK_INFO = 16'hA540;
   localparam logic [15:0] DUMMY_WORD = 16'h55AA;
   localparam logic [15:0] READ_CTL = 16'h2409;
endpackage

// File: rtl/fes_step_gen.sv
module fes_step_gen
   import fes_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic              info_i,
   input  logic [ADDR_W-1:0] erase_addr_i,
   output op_kind_t          kind_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   if (ADDR_W < 16) begin : g_bad_addr
      $error("fes_step_gen: ADDR_W must be at least 16");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("fes_step_gen: DATA_W must be at least 16");
   end

   always_comb begin
      kind_o = OPK_MEMWR;
      addr_o = '0;
      data_o = '0;
      case (step_i)
         3'd0: kind_o = OPK_HALT;
         3'd1: begin
            addr_o = ADDR_W'(REG_MODE);
            data_o = DATA_W'(info_i ? CODE_SEG : CODE_MASS);
         end
         3'd2: begin
            addr_o = ADDR_W'(REG_CLKSEL);
            data_o = DATA_W'(CLKSEL_VAL);
         end
         3'd3: begin
            addr_o = ADDR_W'(REG_LOCK);
            data_o = DATA_W'(info_i ? LOCK_INFO : LOCK_MAIN);
         end
         3'd4: begin
            addr_o = erase_addr_i;
            data_o = DATA_W'(DUMMY_WORD);
         end
         default: begin
            kind_o = OPK_CTL;
            data_o = DATA_W'(READ_CTL);
         end
      endcase
   end
endmodule

// File: rtl/fes_pulse_gen.sv
module fes_pulse_gen #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned HALF_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drop_i,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [HALF_W-1:0] half_i,
   output logic              tclk_o,
   output logic              done_o,
   output logic              run_o
);
   localparam logic [HALF_W-1:0] HALF_ONE = HALF_W'(1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("fes_pulse_gen: CNT_W must be at least 2");
   end
   if (HALF_W < 1) begin : g_bad_half
      $error("fes_pulse_gen: HALF_W must be at least 1");
   end

   logic [CNT_W-1:0]  left_q;
   logic [HALF_W-1:0] ph_q;
   logic [HALF_W-1:0] half_q;
   logic [HALF_W-1:0] half_eff;
   logic              lvl_q;
   logic              run_q;
   logic              done_q;

   assign half_eff = (half_i == '0) ? HALF_ONE : half_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         ph_q   <= '0;
         half_q <= HALF_ONE;
         lvl_q  <= 1'b1;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (drop_i) begin
            lvl_q <= 1'b0;
         end
         if (start_i) begin
            half_q <= half_eff;
            ph_q   <= half_eff - HALF_ONE;
            left_q <= count_i;
            if (count_i == '0) begin
               lvl_q  <= 1'b1;
               done_q <= 1'b1;
            end else begin
               run_q <= 1'b1;
            end
         end else if (run_q) begin
            if (ph_q != '0) begin
               ph_q <= ph_q - HALF_ONE;
            end else begin
               ph_q <= half_q - HALF_ONE;
               if (!lvl_q) begin
                  lvl_q <= 1'b1;
               end else if (left_q == CNT_ONE) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  lvl_q  <= 1'b0;
                  left_q <= left_q - CNT_ONE;
               end
            end
         end
      end
   end

   assign tclk_o = lvl_q;
   assign done_o = done_q;
   assign run_o  = run_q;

   p_done_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> tclk_o);
   p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !run_o);
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
   import fes_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned HALF_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_info,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_pulses,
   input  logic [HALF_W-1:0] cfg_half,
   output logic              busy_o,
   output logic              done_o,
   output logic              op_valid,
   output logic [1:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   input  logic              op_ready,
   output logic              tclk_o
);
   typedef enum logic [1:0] {ST_IDLE, ST_OPS, ST_PULSE} state_t;

   state_t            state_q;
   logic [STEP_W-1:0] step_q;
   logic              info_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HALF_W-1:0] half_q;
   logic              accept;
   logic              hs;
   logic              pg_drop;
   logic              pg_start;
   logic              pg_done;
   logic              pg_run;
   op_kind_t          kind_w;

   assign accept   = cmd_valid && (state_q == ST_IDLE);
   assign op_valid = (state_q == ST_OPS);
   assign hs       = op_valid && op_ready;
   assign pg_drop  = hs && (step_q == STEP_DUMMY);
   assign pg_start = hs && (step_q == STEP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         info_q  <= 1'b0;
         addr_q  <= '0;
         cnt_q   <= '0;
         half_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_OPS;
               step_q  <= '0;
               info_q  <= cmd_info;
               addr_q  <= cmd_addr;
               cnt_q   <= cmd_pulses;
               half_q  <= cfg_half;
            end
            ST_OPS: if (hs) begin
               if (step_q == STEP_LAST) begin
                  state_q <= ST_PULSE;
               end else begin
                  step_q <= step_q + 3'd1;
               end
            end
            ST_PULSE: if (pg_done) begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   fes_step_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step (
      .step_i      (step_q),
      .info_i      (info_q),
      .erase_addr_i(addr_q),
      .kind_o      (kind_w),
      .addr_o      (op_addr),
      .data_o      (op_data)
   );
   assign op_kind = kind_w;

   fes_pulse_gen #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .drop_i (pg_drop),
      .start_i(pg_start),
      .count_i(cnt_q),
      .half_i (half_q),
      .tclk_o (tclk_o),
      .done_o (pg_done),
      .run_o  (pg_run)
   );

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = pg_done;

   p_hold_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_addr) && $stable(op_data));
   p_ctl_tclk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_kind == 2'd2) |-> !tclk_o);
   p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(done_o));
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !op_valid && tclk_o);
   p_no_op_pulsing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pg_run |-> !op_valid);
   p_first_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> op_valid && (op_kind == 2'd0));
endmodule

// File: tb/fes_erase_seq_bench.sv
module fes_erase_seq_bench;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 16;
   localparam int CNT_W = 16;
   localparam int HALF_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_info = 1'b0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [CNT_W-1:0] cmd_pulses = '0;
   logic [HALF_W-1:0] cfg_half = '0;
   logic busy_o, done_o, op_valid, tclk_o;
   logic [1:0] op_kind;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data;
   logic op_ready = 1'b0;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   fes_erase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .HALF_W(HALF_W)) u_fes_erase_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_info(cmd_info),
      .cmd_addr(cmd_addr), .cmd_pulses(cmd_pulses), .cfg_half(cfg_half),
      .busy_o(busy_o), .done_o(done_o), .op_valid(op_valid), .op_kind(op_kind),
      .op_addr(op_addr), .op_data(op_data), .op_ready(op_ready), .tclk_o(tclk_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_kind(input int step);
      return (step == 0) ? 0 : (step == 5) ? 2 : 1;
   endfunction

   function automatic int exp_addr(input int step, input int addr);
      case (step)
         1: return 'h0128;
         2: return 'h012A;
         3: return 'h012C;
         4: return addr;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_data(input int step, input bit info);
      case (step)
         1: return info ? 'hA502 : 'hA506;
         2: return 'hA540;
         3: return info ? 'hA540 : 'hA500;
         4: return 'h55AA;
         5: return 'h2409;
         default: return 0;
      endcase
   endfunction

   task automatic run_cmd(input bit info, input int addr, input int cnt, input int half, input bit inject);
      int h;
      int rises;
      int bad;
      int runlen;
      int iters;
      bit prev;
      h = (half == 0) ? 1 : half;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_info = info;
      cmd_addr = ADDR_W'(addr);
      cmd_pulses = CNT_W'(cnt);
      cfg_half = HALF_W'(half);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after accept", int'(busy_o), 1);
      chk(op_valid && op_kind == 2'd0, "R2 halt offered", int'(op_kind), 0);
      for (int step = 0; step < 6; step++) begin
         int d;
         chk(op_valid == 1'b1, "R3 op valid", int'(op_valid), 1);
         chk(int'(op_kind) == exp_kind(step), "R3 kind", int'(op_kind), exp_kind(step));
         chk(int'(op_addr) == exp_addr(step, addr), "R3 addr", int'(op_addr), exp_addr(step, addr));
         if (step == 1)
            chk(int'(op_data) == exp_data(step, info), "R4 erase code", int'(op_data), exp_data(step, info));
         else if (step == 3) begin
            chk(int'(op_data) == exp_data(step, info), "R5 lock value", int'(op_data), exp_data(step, info));
            if (inject)
               chk(int'(op_data) == exp_data(step, info), "R10 command ignored", int'(op_data), exp_data(step, info));
         end else
            chk(int'(op_data) == exp_data(step, info), "R3 data", int'(op_data), exp_data(step, info));
         if (step == 5)
            chk(tclk_o == 1'b0, "R6 tclk low at control shift", int'(tclk_o), 0);
         if (inject && step == 2) begin
            cmd_valid = 1'b1;
            cmd_info = ~info;
            cmd_addr = ADDR_W'(addr ^ 'h0F0F);
            cmd_pulses = CNT_W'(cnt + 3);
         end
         d = $urandom % 3;
         for (int k = 0; k < d; k++) begin
            @(negedge clk);
            chk(op_valid && int'(op_kind) == exp_kind(step) && int'(op_data) == exp_data(step, info),
                "R3 hold while stalled", int'(op_data), exp_data(step, info));
         end
         op_ready = 1'b1;
         @(negedge clk);
         op_ready = 1'b0;
         if (step == 4)
            chk(tclk_o == 1'b0, "R6 tclk dropped after dummy write", int'(tclk_o), 0);
      end
      cmd_valid = 1'b0;
      chk(op_valid == 1'b0, "R3 no op after control shift", int'(op_valid), 0);
      rises = 0;
      bad = 0;
      runlen = 0;
      iters = 0;
      prev = 1'b0;
      while (!done_o && iters < 150000) begin
         if (tclk_o == prev) runlen++;
         else begin
            if (runlen != h) bad++;
            if (tclk_o) rises++;
            prev = tclk_o;
            runlen = 1;
         end
         iters++;
         @(negedge clk);
      end
      if (cnt > 0 && runlen != h) bad++;
      chk(rises == cnt, "R7 pulse count", rises, cnt);
      chk(bad == 0, "R7 phase lengths", bad, 0);
      chk(tclk_o == 1'b1, "R7 tclk high at end", int'(tclk_o), 1);
      if (cnt == 0)
         chk(iters == 0, "R8 done right after control shift", iters, 0);
      chk(busy_o == 1'b1, "R9 busy in done cycle", int'(busy_o), 1);
      @(negedge clk);
      chk(busy_o == 1'b0, "R9 busy falls", int'(busy_o), 0);
      chk(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
      chk(op_valid == 1'b0, "R1 op_valid reset", int'(op_valid), 0);
      chk(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
      chk(tclk_o == 1'b1, "R1 tclk reset", int'(tclk_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && tclk_o == 1'b1, "R1 idle after reset", int'(busy_o), 0);
      run_cmd(1'b0, 'hFFFE, 'h3000, 1, 1'b0);
      run_cmd(1'b1, 'h1000, 'h3000, 1, 1'b1);
      run_cmd(1'b0, 'hFFFE, 0, 3, 1'b0);
      run_cmd(1'b1, 'h1000, 1, 0, 1'b0);
      run_cmd(1'b0, 'h8000, 2, 15, 1'b1);
      for (int n = 0; n < 8; n++) begin
         run_cmd(1'($urandom), int'($urandom % 65536), int'($urandom % 13),
                 int'($urandom % 4), 1'($urandom));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule